// File: doc/BRIEF.md
# DVFS Clock-Switch Sequencer

This block moves a CPU core clock from one performance level to another. A start pulse carries the current level and the target level. The block then runs the clock-tree reconfiguration steps in hardware: it selects which PLL drives the core, rewrites the PLL multiplier/divider word, loads a lock-time count, and writes two divider configuration words. Before each next step it waits on a handshake: mux status, PLL lock, or divider busy flags.

There are 14 levels. Level 0 is the fastest (1500 MHz) and level 13 the slowest (200 MHz), in 100 MHz steps. The per-level settings come from an internal lookup. The order of the steps depends on the direction of the change. When the new level keeps the same PLL multiplier and pre-divider, the block rewrites only the post-divider field. It skips the relock and leaves the core on its PLL. Each wait is bounded by a programmable limit, so a handshake that never arrives cannot hang the block.

Top module: `dvfs_seq`

## Requirements
- R1: A request is rejected when the target is 0 or 14 and above, or when the current level is 14 and above. A rejected request produces `done` one cycle after `start` with `err`=1, and none of the write strobes pulse.
- R2: A request with equal current and target levels (and a valid target) produces `done` one cycle after `start` with `err`=0, and none of the write strobes pulse.
- R3: `pll_word` holds M in bits 25:16, P in bits 13:8 and S in bits 2:0. Bit 31 is 1 from reset, and the sequencer never alters bits outside M, P and S. The M/P/S triples per level are: 0:250/4/0, 1:175/3/0, 2:325/6/0, 3:200/4/0, 4:275/6/0, 5:125/3/0, 6:150/4/0, 7:100/3/0, 8:175/3/1, 9:200/4/1, 10:125/3/1, 11:100/3/1, 12:200/4/2, 13:100/3/2.
- R4: After a change, `div0_word` and `div1_word` hold the target level's words (hex). For div0, levels 0..13 give 02160730, 02160730, 02150730, 02150730, 02140630, 01140520, 01130520, 01130520, 01130420, 01130420, 01130420, 01130420, 01120420, 01110310. For div1 (three-field variant), levels 0..13 give 706, 606, 605, 505, 504, 404, 403, 303, 303, 203, 203, 103, 103, 003.
- R5: When M or P differ between the old and new levels, a full change runs in this order:
  - drive `mux_sel` to 0 (alternate PLL) and wait for `mux_stat`=2;
  - pulse `lock_we` with `lock_cnt`=P×250 and pulse `pll_we` with the new fields;
  - wait for `pll_lock`;
  - drive `mux_sel` to 1 and wait for `mux_stat`=1.
- R6: When M and P are equal, only the S field of `pll_word` changes. `pll_we` pulses once, `mux_sel` stays 1 and `lock_we` never pulses.
- R7: When the target index is below the current one, both divider writes come before the PLL write. When it is above, the PLL write comes before the divider writes.
- R8: After the div0 write, the block stalls while any of bits 0,4,8,...,28 of `div0_stat` is 1. Every other bit of `div0_stat` is ignored.
- R9: After the div1 write, the block stalls while any of bits 1:0 of `div1_stat` is 1. When `DIV1_THREE`=1, bit 2 is also checked.
- R10: `busy` is high from the cycle after an accepted start until the cycle of `done`. `done` is a one-cycle pulse. A `start` while busy is ignored.
- R11: Handshake sampling begins in the second cycle of each wait. If the handshake is still pending on sample number `timeout_lim`, the block returns to idle with `done` and `err`=1. A handshake met exactly on that sample completes normally.
- R12: Out of reset, `busy`, `done`, `err` and all strobes are 0 and `mux_sel` is 1. The words hold the level-7 settings: `pll_word`=80640300, `div0_word`=01130520, `div1_word`=303.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse |
| cur_lvl | input | 4 | Current level index |
| tgt_lvl | input | 4 | Target level index |
| timeout_lim | input | 16 | Handshake samples allowed per wait |
| mux_sel | output | 1 | Core clock source: 1 main PLL, 0 alternate PLL |
| mux_stat | input | 3 | Mux status: 1 main, 2 alternate |
| pll_word | output | 32 | PLL configuration word |
| pll_we | output | 1 | PLL word write strobe |
| lock_cnt | output | 16 | PLL lock-time count |
| lock_we | output | 1 | Lock count write strobe |
| pll_lock | input | 1 | PLL locked |
| div0_word | output | 32 | First divider group word |
| div0_we | output | 1 | First divider write strobe |
| div0_stat | input | 32 | First divider busy flags |
| div1_word | output | 32 | Second divider group word |
| div1_we | output | 1 | Second divider write strobe |
| div1_stat | input | 3 | Second divider busy flags |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Last request rejected or timed out |

## Verification
The risky coincidence is a handshake that arrives on the same sample where the timeout limit is reached. Both the completion branch and the abort branch are live in that cycle.

The bench models the div0 busy flag for a known number of cycles. It then runs one S-only change twice. First the limit is one sample too short, and the request must end with `err` set. Then the limit equals exactly the sample on which the flag clears, and the request must complete cleanly with the target divider word in place. A second coincidence also gets a check: a fresh `start` raised in the middle of a running change must leave no trace in the final words.

// File: rtl/dvfs_seq.sv
`timescale 1ns/1ps
module dvfs_seq #(
  parameter int LVL_W     = 4,
  parameter int TMR_W     = 16,
  parameter int LOCK_W    = 16,
  parameter int LOCK_MULT = 250,
  parameter int RST_LVL   = 7,
  parameter bit DIV1_THREE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LVL_W-1:0]  cur_lvl,
  input  logic [LVL_W-1:0]  tgt_lvl,
  input  logic [TMR_W-1:0]  timeout_lim,
  output logic              mux_sel,
  input  logic [2:0]        mux_stat,
  output logic [31:0]       pll_word,
  output logic              pll_we,
  output logic [LOCK_W-1:0] lock_cnt,
  output logic              lock_we,
  input  logic              pll_lock,
  output logic [31:0]       div0_word,
  output logic              div0_we,
  input  logic [31:0]       div0_stat,
  output logic [31:0]       div1_word,
  output logic              div1_we,
  input  logic [2:0]        div1_stat,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int          NUM_LVL   = 14;
  localparam logic [31:0] PLL_FMASK = 32'h03FF_3F07;
  localparam logic [31:0] D0_MASK   = 32'h1111_1111;
  localparam logic [2:0]  D1_MASK   = DIV1_THREE ? 3'b111 : 3'b011;

  typedef enum logic [2:0] {S_IDLE, S_DISP, S_D0, S_D1, S_MALT, S_LOCK, S_MMAIN} st_t;

  function automatic logic [31:0] pms_of(input logic [LVL_W-1:0] l);
    logic [9:0] m;
    logic [5:0] p;
    logic [2:0] s;
    case (int'(l))
      0:  begin m = 10'd250; p = 6'd4; s = 3'd0; end
      1:  begin m = 10'd175; p = 6'd3; s = 3'd0; end
      2:  begin m = 10'd325; p = 6'd6; s = 3'd0; end
      3:  begin m = 10'd200; p = 6'd4; s = 3'd0; end
      4:  begin m = 10'd275; p = 6'd6; s = 3'd0; end
      5:  begin m = 10'd125; p = 6'd3; s = 3'd0; end
      6:  begin m = 10'd150; p = 6'd4; s = 3'd0; end
      7:  begin m = 10'd100; p = 6'd3; s = 3'd0; end
      8:  begin m = 10'd175; p = 6'd3; s = 3'd1; end
      9:  begin m = 10'd200; p = 6'd4; s = 3'd1; end
      10: begin m = 10'd125; p = 6'd3; s = 3'd1; end
      11: begin m = 10'd100; p = 6'd3; s = 3'd1; end
      12: begin m = 10'd200; p = 6'd4; s = 3'd2; end
      default: begin m = 10'd100; p = 6'd3; s = 3'd2; end
    endcase
    return {6'd0, m, 2'd0, p, 5'd0, s};
  endfunction

  function automatic logic [31:0] div0_of(input logic [LVL_W-1:0] l);
    int i;
    logic [3:0] m0, m1, atb, apl;
    i   = int'(l);
    m0  = (i <= 4) ? 4'd3 : (i <= 12) ? 4'd2 : 4'd1;
    m1  = (i <= 3) ? 4'd7 : (i == 4) ? 4'd6 : (i <= 7) ? 4'd5 : (i <= 12) ? 4'd4 : 4'd3;
    atb = (i <= 1) ? 4'd6 : (i <= 3) ? 4'd5 : (i <= 5) ? 4'd4 : (i <= 11) ? 4'd3 :
          (i == 12) ? 4'd2 : 4'd1;
    apl = (i <= 4) ? 4'd2 : 4'd1;
    return {4'd0, apl, 4'd1, atb, 4'd0, m1, m0, 4'd0};
  endfunction

  function automatic logic [31:0] div1_of(input logic [LVL_W-1:0] l);
    int i;
    logic [3:0] cp, cs;
    i  = int'(l);
    cp = (i <= 1) ? 4'd6 : (i <= 3) ? 4'd5 : (i <= 5) ? 4'd4 : 4'd3;
    cs = DIV1_THREE ? 4'((14 - i) / 2) : 4'd0;
    return {20'd0, cs, 4'd0, cp};
  endfunction

  st_t              st;
  logic [LVL_W-1:0] tgt_q;
  logic             up_q, full_q, div_done, pll_done;
  logic [TMR_W-1:0] tmr;
  logic             hs_ok;

  wire  [31:0] tgt_pms = pms_of(tgt_q);
  wire  bad_req = (tgt_lvl == '0) || (int'(tgt_lvl) >= NUM_LVL) || (int'(cur_lvl) >= NUM_LVL);
  wire  full_in = pms_of(cur_lvl)[31:8] != pms_of(tgt_lvl)[31:8];
  wire  wait_st = (st != S_IDLE) && (st != S_DISP);
  wire  sample  = tmr != '0;
  wire  tmo     = sample && !hs_ok && (tmr == timeout_lim);

  assign busy = st != S_IDLE;

  always_comb begin
    case (st)
      S_D0:    hs_ok = (div0_stat & D0_MASK) == '0;
      S_D1:    hs_ok = (div1_stat & D1_MASK) == '0;
      S_MALT:  hs_ok = mux_stat == 3'd2;
      S_LOCK:  hs_ok = pll_lock;
      S_MMAIN: hs_ok = mux_stat == 3'd1;
      default: hs_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tgt_q     <= '0;
      up_q      <= 1'b0;
      full_q    <= 1'b0;
      div_done  <= 1'b0;
      pll_done  <= 1'b0;
      tmr       <= '0;
      mux_sel   <= 1'b1;
      pll_word  <= 32'h8000_0000 | pms_of(LVL_W'(RST_LVL));
      lock_cnt  <= '0;
      div0_word <= div0_of(LVL_W'(RST_LVL));
      div1_word <= div1_of(LVL_W'(RST_LVL));
      pll_we    <= 1'b0;
      lock_we   <= 1'b0;
      div0_we   <= 1'b0;
      div1_we   <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      pll_we  <= 1'b0;
      lock_we <= 1'b0;
      div0_we <= 1'b0;
      div1_we <= 1'b0;
      done    <= 1'b0;
      if (wait_st) tmr <= tmr + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          if (bad_req) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else if (cur_lvl == tgt_lvl) begin
            done <= 1'b1;
            err  <= 1'b0;
          end else begin
            tgt_q    <= tgt_lvl;
            up_q     <= tgt_lvl < cur_lvl;
            full_q   <= full_in;
            div_done <= 1'b0;
            pll_done <= 1'b0;
            err      <= 1'b0;
            st       <= S_DISP;
          end
        end
        S_DISP: begin
          tmr <= '0;
          if (!div_done && (up_q || pll_done)) begin
            div0_word <= div0_of(tgt_q);
            div0_we   <= 1'b1;
            st        <= S_D0;
          end else if (!pll_done) begin
            if (full_q) begin
              mux_sel <= 1'b0;
              st      <= S_MALT;
            end else begin
              pll_word[2:0] <= tgt_pms[2:0];
              pll_we        <= 1'b1;
              pll_done      <= 1'b1;
            end
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: begin
          if (sample && hs_ok) begin
            tmr <= '0;
            case (st)
              S_D0: begin
                div1_word <= div1_of(tgt_q);
                div1_we   <= 1'b1;
                st        <= S_D1;
              end
              S_D1: begin
                div_done <= 1'b1;
                st       <= S_DISP;
              end
              S_MALT: begin
                lock_cnt <= LOCK_W'(int'(tgt_pms[13:8]) * LOCK_MULT);
                lock_we  <= 1'b1;
                pll_word <= (pll_word & ~PLL_FMASK) | tgt_pms;
                pll_we   <= 1'b1;
                st       <= S_LOCK;
              end
              S_LOCK: begin
                mux_sel <= 1'b1;
                st      <= S_MMAIN;
              end
              S_MMAIN: begin
                pll_done <= 1'b1;
                st       <= S_DISP;
              end
              default: st <= S_IDLE;
            endcase
          end else if (tmo) begin
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dvfs_seq_chk.sv
`timescale 1ns/1ps
module dvfs_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mux_sel,
  input logic [2:0]  mux_stat,
  input logic        pll_lock,
  input logic        pll_we,
  input logic        lock_we,
  input logic        div0_we,
  input logic        div1_we,
  input logic [31:0] div0_stat
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_we || div0_we || div1_we || lock_we) |-> busy);

  a_r5_lock_on_alt: assert property (@(posedge clk) disable iff (!rst_n)
    lock_we |-> !mux_sel);

  a_r5_lock_after_mux: assert property (@(posedge clk) disable iff (!rst_n)
    lock_we |-> $past(mux_stat) == 3'd2);

  a_r5_back_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_sel) |-> $past(pll_lock));

  a_r8_div1_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    div1_we |-> ($past(div0_stat) & 32'h1111_1111) == 32'h0);
endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mux_sel(mux_sel),
  .mux_stat(mux_stat), .pll_lock(pll_lock), .pll_we(pll_we), .lock_we(lock_we),
  .div0_we(div0_we), .div1_we(div1_we), .div0_stat(div0_stat)
);

// File: tb/sim_dvfs_seq.sv
`timescale 1ns/1ps
module sim_dvfs_seq;
  localparam int EM[14] = '{250,175,325,200,275,125,150,100,175,200,125,100,200,100};
  localparam int EP[14] = '{4,3,6,4,6,3,4,3,3,4,3,3,4,3};
  localparam int ES[14] = '{0,0,0,0,0,0,0,0,1,1,1,1,2,2};
  localparam logic [31:0] ED0[14] = '{32'h02160730, 32'h02160730, 32'h02150730, 32'h02150730,
    32'h02140630, 32'h01140520, 32'h01130520, 32'h01130520, 32'h01130420, 32'h01130420,
    32'h01130420, 32'h01130420, 32'h01120420, 32'h01110310};
  localparam logic [31:0] ED1[14] = '{32'h706, 32'h606, 32'h605, 32'h505, 32'h504, 32'h404,
    32'h403, 32'h303, 32'h303, 32'h203, 32'h203, 32'h103, 32'h103, 32'h003};
  localparam logic [8:0] VEC[10] = '{{4'd7,4'd1,1'b1}, {4'd1,4'd8,1'b0}, {4'd8,4'd3,1'b1},
    {4'd3,4'd9,1'b0}, {4'd9,4'd12,1'b0}, {4'd12,4'd13,1'b1}, {4'd13,4'd11,1'b0},
    {4'd11,4'd5,1'b1}, {4'd5,4'd10,1'b0}, {4'd10,4'd2,1'b1}};
  localparam int D0N = 3;
  localparam int D1N = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] cur_lvl = 0, tgt_lvl = 0;
  logic [15:0] timeout_lim = 16'd100;
  logic mux_sel, pll_we, lock_we, pll_lock, div0_we, div1_we, busy, done, err;
  logic [2:0] mux_stat = 3'd1;
  logic [31:0] pll_word, div0_word, div1_word, div0_stat, force0 = 0;
  logic [2:0] div1_stat, force1 = 0;
  logic [15:0] lock_cnt;
  logic lock_hold = 0;
  int d0c = 0, d1c = 0, lcnt = 0;
  int checks = 0, failures = 0;
  int n_d0, n_d1, n_pll, n_lock, n_mfall, n_done, t_d0, t_d1, t_pll, lock_seen;
  int inj_at = -1, rel_at = -1, busy_rel, d1_rel;
  bit got_done, got_err, prev_mux;

  always #2.5 clk = ~clk;

  dvfs_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .cur_lvl(cur_lvl), .tgt_lvl(tgt_lvl),
    .timeout_lim(timeout_lim), .mux_sel(mux_sel), .mux_stat(mux_stat), .pll_word(pll_word),
    .pll_we(pll_we), .lock_cnt(lock_cnt), .lock_we(lock_we), .pll_lock(pll_lock),
    .div0_word(div0_word), .div0_we(div0_we), .div0_stat(div0_stat), .div1_word(div1_word),
    .div1_we(div1_we), .div1_stat(div1_stat), .busy(busy), .done(done), .err(err));

  always_ff @(posedge clk) begin
    mux_stat <= mux_sel ? 3'd1 : 3'd2;
    if (div0_we) d0c <= D0N; else if (d0c != 0) d0c <= d0c - 1;
    if (div1_we) d1c <= D1N; else if (d1c != 0) d1c <= d1c - 1;
    if (lock_we) lcnt <= 4; else if (lcnt != 0) lcnt <= lcnt - 1;
  end
  assign div0_stat = ((d0c != 0) ? 32'h0001_0000 : 32'h0) | force0;
  assign div1_stat = ((d1c != 0) ? 3'b001 : 3'b000) | force1;
  assign pll_lock  = (lcnt == 0) && !lock_hold;

  function automatic logic [31:0] exp_pll(input int l);
    return 32'h8000_0000 | (32'(EM[l]) << 16) | (32'(EP[l]) << 8) | 32'(ES[l]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input int c, input int t);
    n_d0 = 0; n_d1 = 0; n_pll = 0; n_lock = 0; n_mfall = 0; n_done = 0;
    t_d0 = -1; t_d1 = -1; t_pll = -1; lock_seen = -1; busy_rel = 0; d1_rel = 0;
    got_done = 0; got_err = 0;
    @(negedge clk);
    prev_mux = mux_sel;
    start = 1; cur_lvl = 4'(c); tgt_lvl = 4'(t);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      start = 0;
      if (k == inj_at) begin start = 1; cur_lvl = 4'd12; tgt_lvl = 4'd1; end
      if (k == rel_at - 1) begin busy_rel = busy; d1_rel = n_d1; end
      if (k == rel_at) begin force0 = 0; force1 = 0; end
      if (div0_we) begin n_d0++; t_d0 = k; end
      if (div1_we) begin n_d1++; t_d1 = k; end
      if (pll_we) begin n_pll++; t_pll = k; end
      if (lock_we) begin n_lock++; lock_seen = int'(lock_cnt); end
      if (prev_mux && !mux_sel) n_mfall++;
      prev_mux = mux_sel;
      if (done) begin got_done = 1; got_err = err; n_done++; break; end
    end
    start = 0;
    inj_at = -1; rel_at = -1;
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !err && mux_sel && !pll_we && !lock_we && !div0_we && !div1_we,
        "R12 idle", {busy, done, err, mux_sel}, 32'h1);
    chk(pll_word == exp_pll(7), "R12 pll", pll_word, exp_pll(7));
    chk(div0_word == ED0[7] && div1_word == ED1[7], "R12 div", div0_word, ED0[7]);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      int c, t;
      bit f;
      c = int'(VEC[i][8:5]); t = int'(VEC[i][4:1]); f = VEC[i][0];
      run_op(c, t);
      chk(got_done && !got_err, "R10 done no err", {got_done, got_err}, 32'h2);
      chk(pll_word == exp_pll(t), "R3 pll word", pll_word, exp_pll(t));
      chk(div0_word == ED0[t], "R4 div0", div0_word, ED0[t]);
      chk(div1_word == ED1[t], "R4 div1", div1_word, ED1[t]);
      chk(n_lock == int'(f) && n_mfall == int'(f) && n_pll == 1, f ? "R5 full" : "R6 s-only",
          {n_lock[7:0], n_mfall[7:0], n_pll[7:0]}, {8'(f), 8'(f), 8'd1});
      chk(mux_sel, "R5 mux back", mux_sel, 1);
      if (f) chk(lock_seen == EP[t] * 250, "R5 lock count", lock_seen, EP[t] * 250);
      if (t < c) chk(t_d1 >= 0 && t_d1 < t_pll, "R7 up order", t_d1, t_pll);
      else chk(t_pll >= 0 && t_pll < t_d0, "R7 down order", t_pll, t_d0);
      @(negedge clk);
      chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);
    end

    // R2 equal level
    run_op(2, 2);
    chk(got_done && !got_err && n_d0 + n_d1 + n_pll + n_lock == 0, "R2 equal",
        n_d0 + n_pll + n_lock, 0);
    // R1 unsupported
    run_op(2, 0);
    chk(got_done && got_err && n_d0 + n_pll + n_lock == 0, "R1 target 0", got_err, 1);
    run_op(2, 14);
    chk(got_done && got_err && n_d0 + n_pll + n_lock == 0, "R1 target 14", got_err, 1);
    run_op(15, 5);
    chk(got_done && got_err && pll_word == exp_pll(2), "R1 current 15", pll_word, exp_pll(2));

    // R11 lock never arrives
    lock_hold = 1; timeout_lim = 16'd20;
    run_op(2, 9);
    chk(got_done && got_err && !mux_sel, "R11 lock timeout", {got_err, mux_sel}, 32'h2);
    lock_hold = 0; timeout_lim = 16'd100;
    run_op(2, 9);
    chk(got_done && !got_err && mux_sel && pll_word == exp_pll(9) && div0_word == ED0[9],
        "R11 recover", pll_word, exp_pll(9));

    // R11 limit one sample short, then exact
    timeout_lim = 16'(D0N);
    run_op(9, 12);
    chk(got_done && got_err, "R11 short limit", got_err, 1);
    timeout_lim = 16'(D0N + 1);
    run_op(9, 12);
    chk(got_done && !got_err && div0_word == ED0[12] && div1_word == ED1[12],
        "R11 exact limit", div0_word, ED0[12]);
    timeout_lim = 16'd100;

    // R10 start while busy ignored
    inj_at = 2;
    run_op(12, 13);
    chk(got_done && !got_err && pll_word == exp_pll(13), "R10 ignore start", pll_word, exp_pll(13));
    repeat (6) begin
      @(negedge clk);
      chk(!busy && !done, "R10 no second op", {busy, done}, 0);
    end

    // R8 non-nibble bit ignored
    force0 = 32'h0000_0002;
    run_op(13, 11);
    chk(got_done && !got_err && div1_word == ED1[11], "R8 bit1 ignored", div1_word, ED1[11]);
    force0 = 0;

    // R8 bit 28 stalls
    force0 = 32'h1000_0000; rel_at = 40;
    run_op(11, 5);
    chk(busy_rel == 1 && d1_rel == 0, "R8 bit28 stall", {busy_rel[7:0], d1_rel[7:0]}, 32'h100);
    chk(got_done && !got_err && div0_word == ED0[5], "R8 after release", div0_word, ED0[5]);

    // R9 third bit stalls
    force1 = 3'b100; rel_at = 40;
    run_op(5, 10);
    chk(busy_rel == 1, "R9 bit2 stall", busy_rel, 1);
    chk(got_done && !got_err && div1_word == ED1[10], "R9 after release", div1_word, ED1[10]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule